// File: doc/BRIEF.md
# Battery Monitor Power-Mode Controller

This block holds the operating mode of a battery monitor and turns it into control levels for the rest of the chip. There are five states. ACTIVE (`PM_ACTIVE`) measures continuously with protections armed. SLEEP (`PM_SLEEP`) keeps the discharge path closed and arms protections, but measures only in timed bursts. DEEP (`PM_DEEP`) opens every switch and stops all monitoring. OFF (`PM_OFF`) is the powered-down state in which nothing is retained. CFG (`PM_CFG`) is a configuration-edit state in which parameters may be changed.

The host moves the controller by issuing a 3-bit command with a valid strobe. A wake input is the only way out of OFF. The block drives four switch enables (charge, precharge, discharge, predischarge), a protection enable, a continuous-measurement enable, a one-cycle measurement-burst pulse, a core and two auxiliary regulator enables, an oscillator fast-rate select and an oscillator enable, and a register-retention flag. It also reports the current mode and a one-cycle error pulse for rejected commands.

Four configuration fields are held inside the block: the charge-off-in-sleep bit, the auxiliary-keep-in-deep bit, the oscillator-gate-in-deep bit and the sleep burst interval. They can be written only in CFG, and they return to their defaults whenever OFF is entered.

Top module: `bms_pwr_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 0 (ACTIVE), `cmd_err_o` is 0, and the configuration holds its defaults: charge-off 0, aux-keep 0, oscillator-gate 0, interval `DEF_IVL`.
- R2: The command codes are 1 go-active, 2 go-sleep, 3 go-deep, 4 shutdown, 5 enter-config and 6 exit-config. The mode codes are 0 ACTIVE, 1 SLEEP, 2 DEEP, 3 OFF and 4 CFG. Named transitions take effect on the clock edge that samples the command: ACTIVE→SLEEP (2), ACTIVE→DEEP (3), ACTIVE→CFG (5), SLEEP→ACTIVE (1), DEEP→ACTIVE (1), CFG→ACTIVE (6).
- R3: Shutdown (4) moves every mode except OFF to OFF. In OFF all commands are ignored and raise no error. Only `wake_i` leaves OFF, and it always goes to ACTIVE.
- R4: Any other command in a non-OFF mode, including codes 0 and 7, leaves the mode unchanged and drives `cmd_err_o` high for the single following cycle.
- R5: In ACTIVE, all four switch enables, protection, continuous measurement, core and both auxiliary regulators, oscillator enable, fast rate and retention are 1.
- R6: In SLEEP, discharge is 1 and charge equals the inverse of the charge-off bit. Precharge and predischarge are 0. Protection is 1 and continuous measurement is 0. Regulators are all 1, the rate is slow, the oscillator is on, and retention is 1.
- R7: In SLEEP with interval N, `meas_burst_o` is first high N cycles after entry and then every N+1 cycles, high for one cycle each time. An interval of 0 pulses every cycle. The pulse is never high outside SLEEP.
- R8: In DEEP, all switches, protection and measurement are 0. The core regulator is 1 and both auxiliary regulators equal the aux-keep bit. The rate is slow, the oscillator enable is the inverse of the gate bit, and retention is 1.
- R9: In OFF every output listed in R5, including retention, is 0.
- R10: In CFG, switches, protection and measurement are 0, while regulators, oscillator, fast rate and retention are 1. A `cfg_wr_i` strobe loads the configuration only in CFG and is ignored in every other mode.
- R11: Entering OFF restores the R1 configuration defaults, and these are in effect after the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (R2) |
| wake_i | input | 1 | Wake request, used only in OFF |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_chg_off_i | input | 1 | Charge-off-in-sleep value to write |
| cfg_aux_keep_i | input | 1 | Aux-regulators-kept-in-deep value to write |
| cfg_osc_gate_i | input | 1 | Oscillator-gated-in-deep value to write |
| cfg_ivl_i | input | IW | Sleep burst interval to write |
| mode_o | output | 3 | Current mode code |
| chg_en_o | output | 1 | Charge switch enable |
| pchg_en_o | output | 1 | Precharge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| pdsg_en_o | output | 1 | Predischarge switch enable |
| prot_en_o | output | 1 | Protection enable |
| meas_en_o | output | 1 | Continuous measurement enable |
| meas_burst_o | output | 1 | One-cycle measurement request in SLEEP |
| core_ldo_en_o | output | 1 | Core regulator enable |
| aux_ldo_en_o | output | AUX_N | Auxiliary regulator enables |
| osc_fast_o | output | 1 | 1 selects the fast oscillator rate |
| osc_en_o | output | 1 | Oscillator enable |
| reg_retain_o | output | 1 | Register contents retained |
| cmd_err_o | output | 1 | Rejected-command pulse |

## Verification
The assertions watch several properties on every cycle. They check that shutdown always reaches OFF and that OFF only clears through a wake to ACTIVE. They check that leaving CFG lands in ACTIVE, that an error pulse follows a strobed command without a mode change, and that bursts occur only in SLEEP. They also enforce the fixed switch and protection levels of SLEEP, DEEP and OFF. The configuration-dependent levels need the bench's scenarios: charge in SLEEP, the auxiliary regulators and oscillator gating in DEEP, and the exact burst spacing for a written interval. The same holds for writes being ignored outside CFG and for the defaults coming back after an OFF and wake cycle.

// File: rtl/bms_pm_pkg.sv
package bms_pm_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE = 3'd0,
        PM_SLEEP  = 3'd1,
        PM_DEEP   = 3'd2,
        PM_OFF    = 3'd3,
        PM_CFG    = 3'd4
    } pm_state_e;

    typedef enum logic [2:0] {
        PC_RSVD_LO   = 3'd0,
        PC_GO_ACTIVE = 3'd1,
        PC_GO_SLEEP  = 3'd2,
        PC_GO_DEEP   = 3'd3,
        PC_SHUTDOWN  = 3'd4,
        PC_ENTER_CFG = 3'd5,
        PC_EXIT_CFG  = 3'd6,
        PC_RSVD_HI   = 3'd7
    } pm_cmd_e;

    typedef struct packed {
        logic chg_off;
        logic aux_keep;
        logic osc_gate;
    } pm_cfg_t;

    localparam pm_cfg_t PM_CFG_DEFAULT = '{chg_off: 1'b0, aux_keep: 1'b0, osc_gate: 1'b0};

endpackage

// File: rtl/bms_pm_fsm.sv
module bms_pm_fsm
    import bms_pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_vld_i,
    input  logic [2:0] cmd_i,
    input  logic      wake_i,
    output pm_state_e state_o,
    output pm_state_e next_o,
    output logic      err_o
);

    pm_state_e state_q;
    pm_state_e state_d;
    logic      bad_cmd;
    logic      err_q;
    pm_cmd_e   cmd;

    assign cmd = pm_cmd_e'(cmd_i);

    always_comb begin
        state_d = state_q;
        bad_cmd = 1'b0;
        unique case (state_q)
            PM_ACTIVE: begin
                if (cmd_vld_i) begin
                    unique case (cmd)
                        PC_GO_SLEEP:  state_d = PM_SLEEP;
                        PC_GO_DEEP:   state_d = PM_DEEP;
                        PC_ENTER_CFG: state_d = PM_CFG;
                        PC_SHUTDOWN:  state_d = PM_OFF;
                        default:      bad_cmd = 1'b1;
                    endcase
                end
            end
            PM_SLEEP, PM_DEEP: begin
                if (cmd_vld_i) begin
                    unique case (cmd)
                        PC_GO_ACTIVE: state_d = PM_ACTIVE;
                        PC_SHUTDOWN:  state_d = PM_OFF;
                        default:      bad_cmd = 1'b1;
                    endcase
                end
            end
            PM_CFG: begin
                if (cmd_vld_i) begin
                    unique case (cmd)
                        PC_EXIT_CFG: state_d = PM_ACTIVE;
                        PC_SHUTDOWN: state_d = PM_OFF;
                        default:     bad_cmd = 1'b1;
                    endcase
                end
            end
            PM_OFF: begin
                if (wake_i) begin
                    state_d = PM_ACTIVE;
                end
            end
            default: state_d = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= bad_cmd;
        end
    end

    assign state_o = state_q;
    assign next_o  = state_d;
    assign err_o   = err_q;

endmodule

// File: rtl/bms_pm_cfg_store.sv
module bms_pm_cfg_store
    import bms_pm_pkg::*;
#(
    parameter int unsigned IW      = 8,
    parameter int unsigned DEF_IVL = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pm_state_e     state_i,
    input  logic          wr_i,
    input  pm_cfg_t       cfg_i,
    input  logic [IW-1:0] ivl_i,
    output pm_cfg_t       cfg_o,
    output logic [IW-1:0] ivl_o
);

    localparam logic [IW-1:0] IVL_RST = IW'(DEF_IVL);

    pm_cfg_t       cfg_q;
    logic [IW-1:0] ivl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= PM_CFG_DEFAULT;
            ivl_q <= IVL_RST;
        end else if (state_i == PM_OFF) begin
            cfg_q <= PM_CFG_DEFAULT;
            ivl_q <= IVL_RST;
        end else if (wr_i && (state_i == PM_CFG)) begin
            cfg_q <= cfg_i;
            ivl_q <= ivl_i;
        end
    end

    assign cfg_o = cfg_q;
    assign ivl_o = ivl_q;

endmodule

// File: rtl/bms_pm_burst_timer.sv
module bms_pm_burst_timer #(
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          run_i,
    input  logic [IW-1:0] ivl_i,
    output logic          burst_o
);

    logic [IW-1:0] cnt_q;
    logic          at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_i) begin
            cnt_q <= ivl_i;
        end else if (run_i) begin
            cnt_q <= at_zero ? ivl_i : cnt_q - 1'b1;
        end
    end

    assign burst_o = run_i && at_zero;

endmodule

// File: rtl/bms_pm_out_map.sv
module bms_pm_out_map
    import bms_pm_pkg::*;
#(
    parameter int unsigned AUX_N = 2
) (
    input  pm_state_e        state_i,
    input  pm_cfg_t          cfg_i,
    input  logic             burst_i,
    output logic             chg_o,
    output logic             pchg_o,
    output logic             dsg_o,
    output logic             pdsg_o,
    output logic             prot_o,
    output logic             meas_o,
    output logic             burst_o,
    output logic             core_o,
    output logic [AUX_N-1:0] aux_o,
    output logic             fast_o,
    output logic             osc_o,
    output logic             retain_o
);

    localparam logic [AUX_N-1:0] AUX_ALL = '1;

    always_comb begin
        chg_o    = 1'b0;
        pchg_o   = 1'b0;
        dsg_o    = 1'b0;
        pdsg_o   = 1'b0;
        prot_o   = 1'b0;
        meas_o   = 1'b0;
        burst_o  = 1'b0;
        core_o   = 1'b0;
        aux_o    = '0;
        fast_o   = 1'b0;
        osc_o    = 1'b0;
        retain_o = 1'b0;
        unique case (state_i)
            PM_ACTIVE: begin
                chg_o    = 1'b1;
                pchg_o   = 1'b1;
                dsg_o    = 1'b1;
                pdsg_o   = 1'b1;
                prot_o   = 1'b1;
                meas_o   = 1'b1;
                core_o   = 1'b1;
                aux_o    = AUX_ALL;
                fast_o   = 1'b1;
                osc_o    = 1'b1;
                retain_o = 1'b1;
            end
            PM_SLEEP: begin
                chg_o    = ~cfg_i.chg_off;
                dsg_o    = 1'b1;
                prot_o   = 1'b1;
                burst_o  = burst_i;
                core_o   = 1'b1;
                aux_o    = AUX_ALL;
                osc_o    = 1'b1;
                retain_o = 1'b1;
            end
            PM_DEEP: begin
                core_o   = 1'b1;
                aux_o    = {AUX_N{cfg_i.aux_keep}};
                osc_o    = ~cfg_i.osc_gate;
                retain_o = 1'b1;
            end
            PM_CFG: begin
                core_o   = 1'b1;
                aux_o    = AUX_ALL;
                fast_o   = 1'b1;
                osc_o    = 1'b1;
                retain_o = 1'b1;
            end
            PM_OFF: begin
                retain_o = 1'b0;
            end
            default: begin
                retain_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bms_pwr_mode_ctrl.sv
module bms_pwr_mode_ctrl
    import bms_pm_pkg::*;
#(
    parameter int unsigned IW      = 8,
    parameter int unsigned DEF_IVL = 5,
    parameter int unsigned AUX_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld_i,
    input  logic [2:0]       cmd_i,
    input  logic             wake_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_chg_off_i,
    input  logic             cfg_aux_keep_i,
    input  logic             cfg_osc_gate_i,
    input  logic [IW-1:0]    cfg_ivl_i,
    output logic [2:0]       mode_o,
    output logic             chg_en_o,
    output logic             pchg_en_o,
    output logic             dsg_en_o,
    output logic             pdsg_en_o,
    output logic             prot_en_o,
    output logic             meas_en_o,
    output logic             meas_burst_o,
    output logic             core_ldo_en_o,
    output logic [AUX_N-1:0] aux_ldo_en_o,
    output logic             osc_fast_o,
    output logic             osc_en_o,
    output logic             reg_retain_o,
    output logic             cmd_err_o
);

    pm_state_e     state;
    pm_state_e     state_nxt;
    pm_cfg_t       cfg_wdata;
    pm_cfg_t       cfg_cur;
    logic [IW-1:0] ivl_cur;
    logic          burst_raw;
    logic          sleep_arm;
    logic          in_sleep;

    assign cfg_wdata = '{chg_off: cfg_chg_off_i, aux_keep: cfg_aux_keep_i, osc_gate: cfg_osc_gate_i};
    assign in_sleep  = (state == PM_SLEEP);
    assign sleep_arm = (state_nxt == PM_SLEEP) && !in_sleep;

    bms_pm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld_i (cmd_vld_i),
        .cmd_i     (cmd_i),
        .wake_i    (wake_i),
        .state_o   (state),
        .next_o    (state_nxt),
        .err_o     (cmd_err_o)
    );

    bms_pm_cfg_store #(.IW(IW), .DEF_IVL(DEF_IVL)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .wr_i    (cfg_wr_i),
        .cfg_i   (cfg_wdata),
        .ivl_i   (cfg_ivl_i),
        .cfg_o   (cfg_cur),
        .ivl_o   (ivl_cur)
    );

    bms_pm_burst_timer #(.IW(IW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (sleep_arm),
        .run_i   (in_sleep),
        .ivl_i   (ivl_cur),
        .burst_o (burst_raw)
    );

    bms_pm_out_map #(.AUX_N(AUX_N)) u_map (
        .state_i  (state),
        .cfg_i    (cfg_cur),
        .burst_i  (burst_raw),
        .chg_o    (chg_en_o),
        .pchg_o   (pchg_en_o),
        .dsg_o    (dsg_en_o),
        .pdsg_o   (pdsg_en_o),
        .prot_o   (prot_en_o),
        .meas_o   (meas_en_o),
        .burst_o  (meas_burst_o),
        .core_o   (core_ldo_en_o),
        .aux_o    (aux_ldo_en_o),
        .fast_o   (osc_fast_o),
        .osc_o    (osc_en_o),
        .retain_o (reg_retain_o)
    );

    assign mode_o = state;

endmodule

// File: rtl/bms_pwr_mode_ctrl_chk.sv
module bms_pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_vld_i,
    input logic [2:0] cmd_i,
    input logic       wake_i,
    input logic [2:0] mode_o,
    input logic       chg_en_o,
    input logic       pchg_en_o,
    input logic       dsg_en_o,
    input logic       pdsg_en_o,
    input logic       prot_en_o,
    input logic       meas_en_o,
    input logic       meas_burst_o,
    input logic       core_ldo_en_o,
    input logic       reg_retain_o,
    input logic       cmd_err_o
);

    p_shutdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i == 3'd4 && mode_o != 3'd3) |=> (mode_o == 3'd3));

    p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && !wake_i) |=> (mode_o == 3'd3));

    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && wake_i) |=> (mode_o == 3'd0));

    p_cfg_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && cmd_vld_i && cmd_i == 3'd6) |=> (mode_o == 3'd0));

    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> ($past(cmd_vld_i) && mode_o == $past(mode_o)));

    p_burst_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_burst_o |-> (mode_o == 3'd1));

    p_sleep_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (dsg_en_o && prot_en_o && !pchg_en_o && !pdsg_en_o && !meas_en_o));

    p_deep_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2) |-> !(chg_en_o || pchg_en_o || dsg_en_o || pdsg_en_o || prot_en_o || meas_en_o));

    p_off_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> !(reg_retain_o || core_ldo_en_o || chg_en_o || dsg_en_o || prot_en_o));

endmodule

bind bms_pwr_mode_ctrl bms_pwr_mode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_vld_i     (cmd_vld_i),
    .cmd_i         (cmd_i),
    .wake_i        (wake_i),
    .mode_o        (mode_o),
    .chg_en_o      (chg_en_o),
    .pchg_en_o     (pchg_en_o),
    .dsg_en_o      (dsg_en_o),
    .pdsg_en_o     (pdsg_en_o),
    .prot_en_o     (prot_en_o),
    .meas_en_o     (meas_en_o),
    .meas_burst_o  (meas_burst_o),
    .core_ldo_en_o (core_ldo_en_o),
    .reg_retain_o  (reg_retain_o),
    .cmd_err_o     (cmd_err_o)
);

// File: tb/bms_pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module bms_pwr_mode_ctrl_tb_top;

    localparam int IW      = 8;
    localparam int DEF_IVL = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_vld_i = 1'b0;
    logic [2:0]    cmd_i = 3'd0;
    logic          wake_i = 1'b0;
    logic          cfg_wr_i = 1'b0;
    logic          cfg_chg_off_i = 1'b0;
    logic          cfg_aux_keep_i = 1'b0;
    logic          cfg_osc_gate_i = 1'b0;
    logic [IW-1:0] cfg_ivl_i = '0;
    logic [2:0]    mode_o;
    logic          chg_en_o, pchg_en_o, dsg_en_o, pdsg_en_o, prot_en_o, meas_en_o;
    logic          meas_burst_o, core_ldo_en_o, osc_fast_o, osc_en_o, reg_retain_o, cmd_err_o;
    logic [1:0]    aux_ldo_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    bms_pwr_mode_ctrl #(.IW(IW), .DEF_IVL(DEF_IVL), .AUX_N(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i), .wake_i(wake_i),
        .cfg_wr_i(cfg_wr_i), .cfg_chg_off_i(cfg_chg_off_i), .cfg_aux_keep_i(cfg_aux_keep_i),
        .cfg_osc_gate_i(cfg_osc_gate_i), .cfg_ivl_i(cfg_ivl_i), .mode_o(mode_o),
        .chg_en_o(chg_en_o), .pchg_en_o(pchg_en_o), .dsg_en_o(dsg_en_o), .pdsg_en_o(pdsg_en_o),
        .prot_en_o(prot_en_o), .meas_en_o(meas_en_o), .meas_burst_o(meas_burst_o),
        .core_ldo_en_o(core_ldo_en_o), .aux_ldo_en_o(aux_ldo_en_o), .osc_fast_o(osc_fast_o),
        .osc_en_o(osc_en_o), .reg_retain_o(reg_retain_o), .cmd_err_o(cmd_err_o)
    );

    function automatic logic [11:0] levels();
        return {chg_en_o, pchg_en_o, dsg_en_o, pdsg_en_o, prot_en_o, meas_en_o,
                core_ldo_en_o, aux_ldo_en_o, osc_fast_o, osc_en_o, reg_retain_o};
    endfunction

    // Expected level vector per mode, from R5, R6, R8, R9, R10.
    function automatic logic [11:0] expect_lv(input int m, input logic c, input logic k, input logic g);
        case (m)
            0:       return 12'hFFF;
            1:       return {~c, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1};
            2:       return {4'b0000, 1'b0, 1'b0, 1'b1, k, k, 1'b0, ~g, 1'b1};
            4:       return {4'b0000, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1};
            default: return 12'h000;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [2:0] c);
        cmd_vld_i = 1'b1;
        cmd_i     = c;
        tick();
        cmd_vld_i = 1'b0;
        cmd_i     = 3'd0;
    endtask

    task automatic write_cfg(input logic c, input logic k, input logic g, input logic [IW-1:0] n);
        cfg_wr_i = 1'b1; cfg_chg_off_i = c; cfg_aux_keep_i = k; cfg_osc_gate_i = g; cfg_ivl_i = n;
        tick();
        cfg_wr_i = 1'b0;
    endtask

    task automatic burst_window(input string req, input int n, input int len);
        for (int k = 0; k < len; k++) begin
            check(req, 32'(meas_burst_o), 32'((k % (n + 1)) == n));
            tick();
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode", 32'(mode_o), 0);
        check("R1 err", 32'(cmd_err_o), 0);
        check("R5 active levels", 32'(levels()), 32'(expect_lv(0, 0, 0, 0)));
        check("R5 no burst", 32'(meas_burst_o), 0);
    endtask

    task automatic t_illegal_active();
        send(3'd1);
        check("R4 mode kept", 32'(mode_o), 0);
        check("R4 err pulse", 32'(cmd_err_o), 1);
        tick();
        check("R4 err one cycle", 32'(cmd_err_o), 0);
        send(3'd7);
        check("R4 code7 err", 32'(cmd_err_o), 1);
        send(3'd0);
        check("R4 code0 err", 32'(cmd_err_o), 1);
        check("R4 code0 mode", 32'(mode_o), 0);
    endtask

    task automatic t_cfg_edit();
        send(3'd5);
        check("R2 to cfg", 32'(mode_o), 4);
        check("R10 cfg levels", 32'(levels()), 32'(expect_lv(4, 0, 0, 0)));
        write_cfg(1'b1, 1'b1, 1'b1, 8'd3);
        send(3'd2);
        check("R4 sleep from cfg", 32'(mode_o), 4);
        check("R4 sleep from cfg err", 32'(cmd_err_o), 1);
        send(3'd6);
        check("R2 cfg exit", 32'(mode_o), 0);
        check("R2 exit no err", 32'(cmd_err_o), 0);
        write_cfg(1'b0, 1'b0, 1'b0, 8'd9);
    endtask

    task automatic t_sleep();
        send(3'd2);
        check("R2 to sleep", 32'(mode_o), 1);
        check("R6 sleep levels chg off", 32'(levels()), 32'(expect_lv(1, 1, 0, 0)));
        burst_window("R7 burst ivl3", 3, 12);
        send(3'd3);
        check("R4 deep from sleep", 32'(mode_o), 1);
        tick();
        check("R7 burst absent", 32'(meas_burst_o), 0);
        send(3'd1);
        check("R2 sleep exit", 32'(mode_o), 0);
        check("R7 no burst active", 32'(meas_burst_o), 0);
    endtask

    task automatic t_deep();
        send(3'd3);
        check("R2 to deep", 32'(mode_o), 2);
        check("R8 deep keep gate", 32'(levels()), 32'(expect_lv(2, 0, 1, 1)));
        send(3'd1);
        check("R2 deep exit", 32'(mode_o), 0);
    endtask

    task automatic t_off();
        send(3'd2);
        send(3'd4);
        check("R3 sleep to off", 32'(mode_o), 3);
        check("R9 off levels", 32'(levels()), 0);
        send(3'd1);
        check("R3 cmd ignored in off", 32'(mode_o), 3);
        check("R3 no err in off", 32'(cmd_err_o), 0);
        repeat (3) tick();
        check("R3 off holds", 32'(mode_o), 3);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        check("R3 wake to active", 32'(mode_o), 0);
        send(3'd3);
        check("R11 deep defaults", 32'(levels()), 32'(expect_lv(2, 0, 0, 0)));
        send(3'd4);
        check("R3 deep to off", 32'(mode_o), 3);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        send(3'd5);
        send(3'd4);
        check("R3 cfg to off", 32'(mode_o), 3);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        send(3'd2);
        check("R11 sleep chg default", 32'(chg_en_o), 1);
        burst_window("R11 default interval", DEF_IVL, 14);
        send(3'd1);
    endtask

    task automatic t_zero_ivl();
        send(3'd5);
        write_cfg(1'b0, 1'b0, 1'b0, 8'd0);
        send(3'd6);
        send(3'd2);
        check("R6 sleep levels chg on", 32'(levels()), 32'(expect_lv(1, 0, 0, 0)));
        burst_window("R7 burst ivl0", 0, 5);
        send(3'd1);
        check("R5 back active", 32'(levels()), 32'(expect_lv(0, 0, 0, 0)));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_illegal_active();
        t_cfg_edit();
        t_sleep();
        t_deep_prep();
        t_off();
        t_zero_ivl();
        finish_run();
    end

    // Deep checks need aux-keep and gate set; the write in ACTIVE at the end of
    // t_cfg_edit must have been ignored (R10), so the stored values are still 1.
    task automatic t_deep_prep();
        t_deep();
    endtask

endmodule